// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A directory page is located through a base register. The upper ten address bits select one 4-byte directory entry. A valid directory entry names a page of 1024 table entries, and the middle ten address bits pick one of them. The low twelve bits are the byte offset inside the page and are never translated.

A caller hands over one virtual address at a time on a valid/ready request channel. The walker accepts it only while idle and holds `req_ready` low for the whole walk, which is how back-pressure reaches the caller. The walker then issues reads on a memory port, one at a time. That port uses a valid/ready request channel with a separate response strobe. While `mem_req_ready` is low the walker keeps the same request and address on the port. It never starts a second read before the first read has returned.

The walk ends with a one-cycle `done` pulse that carries either a physical address or a fault code. A directory entry with its valid bit clear ends the walk after one read. Each such entry stands for a 4 MiB region of virtual space that has no table page behind it.

Top module: `pgwalk_top`

## Requirements
- R1: Bits 31:22 of the virtual address are the directory index, bits 21:12 are the table index, and bits 11:0 appear unchanged as bits 11:0 of the physical address.
- R2: The first read of a walk goes to the address base + 4 × directory index, where base is the value held in the base register.
- R3: Bit 0 of an entry is its valid bit and bits 31:12 are its frame number. For a valid directory entry, the second read goes to (frame << 12) + 4 × table index.
- R4: A directory entry with bit 0 clear ends the walk after exactly one read, with fault code 1 and a physical address of zero.
- R5: A table entry with bit 0 clear ends the walk with fault code 2 and a physical address of zero.
- R6: A table entry with bit 0 set ends the walk with fault code 0 and physical address {table frame, offset}.
- R7: `done` is high for exactly one cycle per walk, and `done_paddr` and `done_fault` are meaningful only in that cycle.
- R8: `req_ready` is high only while the walker is idle. A request is taken in a cycle where both `req_valid` and `req_ready` are high, and `req_ready` stays low from the next cycle until the cycle after the `done` pulse.
- R9: `mem_req_valid` and `mem_req_addr` stay fixed until `mem_req_ready` is seen. At most one read is outstanding, and a response is never expected while a request is being offered.
- R10: A base write (`base_wr_en`) takes effect only while the walker is idle. A write during a walk is ignored.
- R11: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Write strobe for the base register (idle only) |
| base_wr_data | input | 32 | New directory base address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request offered |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned entry |
| done | output | 1 | One-cycle walk completion pulse |
| done_paddr | output | 32 | Physical address (zero on a fault) |
| done_fault | output | 2 | 0 = none, 1 = directory fault, 2 = table fault |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, 10-bit indices, a 12-bit offset and a reset base of zero. With these sizes the extreme indices 0 and 1023 and the all-ones address can be reached, so any misplaced index or offset bit changes an address the bench checks. The bench's memory model varies response latency and ready stalls, which exercises the hold rules on the memory request channel. Two base values map the same directory index differently, so the bench can tell whether a base write was taken or ignored.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_TBL  = 2'd2
  } fault_e;

  localparam int ENTRY_BYTES = 4;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [PA_W-1:0]       base,
  input  logic [PA_W-OFS_W-1:0] dir_frame,
  input  logic [PA_W-OFS_W-1:0] tbl_frame,
  output logic [PA_W-1:0]       dir_addr,
  output logic [PA_W-1:0]       tbl_addr,
  output logic [PA_W-1:0]       paddr
);
  localparam int ENT_SH = $clog2(pgwalk_pkg::ENTRY_BYTES);

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [OFS_W-1:0] ofs;

  assign dir_idx = vaddr[VA_W-1 -: IDX_W];
  assign tbl_idx = vaddr[OFS_W +: IDX_W];
  assign ofs     = vaddr[OFS_W-1:0];

  assign dir_addr = base + (PA_W'(dir_idx) << ENT_SH);
  assign tbl_addr = {dir_frame, {OFS_W{1'b0}}} + (PA_W'(tbl_idx) << ENT_SH);
  assign paddr    = {tbl_frame, ofs};
endmodule

// File: rtl/pgwalk_base.sv
module pgwalk_base #(
  parameter int              PA_W     = 32,
  parameter logic [PA_W-1:0] BASE_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  output logic [PA_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)             base_q <= BASE_RST;
    else if (wr_en && idle) base_q <= wr_data;
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic                  idle,
  output logic [VA_W-1:0]       vaddr_q,
  output logic [PA_W-OFS_W-1:0] dir_frame_q,
  input  logic [PA_W-1:0]       dir_addr,
  input  logic [PA_W-1:0]       tbl_addr,
  input  logic [PA_W-1:0]       paddr_calc,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic                  rsp_entry_ok,
  input  logic [PA_W-OFS_W-1:0] rsp_frame,
  output logic                  done,
  output logic [PA_W-1:0]       done_paddr,
  output fault_e                done_fault
);
  walk_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      vaddr_q     <= '0;
      dir_frame_q <= '0;
      done_paddr  <= '0;
      done_fault  <= FLT_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          st_q    <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_req_ready) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (rsp_entry_ok) begin
            dir_frame_q <= rsp_frame;
            st_q        <= ST_TBL_REQ;
          end else begin
            done_fault <= FLT_DIR;
            done_paddr <= '0;
            st_q       <= ST_DONE;
          end
        end
        ST_TBL_REQ: if (mem_req_ready) st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid) begin
          done_fault <= rsp_entry_ok ? FLT_NONE : FLT_TBL;
          done_paddr <= rsp_entry_ok ? paddr_calc : '0;
          st_q       <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle          = (st_q == ST_IDLE);
  assign done          = (st_q == ST_DONE);
  assign mem_req_valid = (st_q == ST_DIR_REQ) || (st_q == ST_TBL_REQ);
  assign mem_req_addr  = (st_q == ST_DIR_REQ) ? dir_addr : tbl_addr;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int              VA_W     = 32,
  parameter int              PA_W     = 32,
  parameter int              OFS_W    = 12,
  parameter int              IDX_W    = 10,
  parameter logic [PA_W-1:0] BASE_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_wr_en,
  input  logic [PA_W-1:0] base_wr_data,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_data,
  output logic            done,
  output logic [PA_W-1:0] done_paddr,
  output logic [1:0]      done_fault
);
  localparam int FRAME_W = PA_W - OFS_W;

  logic               idle;
  logic [PA_W-1:0]    base_q;
  logic [VA_W-1:0]    vaddr_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic [PA_W-1:0]    dir_addr, tbl_addr, paddr_calc;
  logic [FRAME_W-1:0] rsp_frame;
  logic               rsp_entry_ok;
  logic               unused_entry_bits;
  pgwalk_pkg::fault_e fault_w;

  assign rsp_frame         = mem_rsp_data[PA_W-1:OFS_W];
  assign rsp_entry_ok      = mem_rsp_data[0];
  assign unused_entry_bits = ^mem_rsp_data[OFS_W-1:1];
  assign req_ready         = idle;
  assign done_fault        = fault_w;

  pgwalk_base #(.PA_W(PA_W), .BASE_RST(BASE_RST)) u_base (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .wr_en(base_wr_en), .wr_data(base_wr_data), .base_q(base_q)
  );

  pgwalk_addr #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_addr (
    .vaddr(vaddr_q), .base(base_q), .dir_frame(dir_frame_q), .tbl_frame(rsp_frame),
    .dir_addr(dir_addr), .tbl_addr(tbl_addr), .paddr(paddr_calc)
  );

  pgwalk_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .idle(idle), .vaddr_q(vaddr_q), .dir_frame_q(dir_frame_q),
    .dir_addr(dir_addr), .tbl_addr(tbl_addr), .paddr_calc(paddr_calc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .rsp_entry_ok(rsp_entry_ok), .rsp_frame(rsp_frame),
    .done(done), .done_paddr(done_paddr), .done_fault(fault_w)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            done,
  input logic [PA_W-1:0] done_paddr,
  input logic [1:0]      done_fault,
  input logic            base_wr_en,
  input logic [PA_W-1:0] base_q
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_single_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  p_busy_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (done_fault == 2'd1) |-> done_paddr == '0);

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && (done_fault == 2'd2) |-> done_paddr == '0);

  p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_fault != 2'd3);

  p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_en && !req_ready |=> $stable(base_q));
endmodule

bind pgwalk_top pgwalk_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
  .base_wr_en(base_wr_en), .base_q(base_q)
);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE_A = 32'h0004_0000;
  localparam logic [31:0] BASE_B = 32'h0008_0000;
  localparam int NVEC = 8;
  // {expected fault, virtual address}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 32'h0040_1123},
    {2'd1, 32'h0000_0ABC},
    {2'd2, 32'h00C0_4FFF},
    {2'd0, 32'hFFFF_FFFF},
    {2'd1, 32'h8000_0000},
    {2'd0, 32'h0140_2000},
    {2'd0, 32'h556A_A5A5},
    {2'd2, 32'h01C0_0010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] done_paddr;
  logic [1:0]  done_fault;

  int n_checks = 0;
  int n_fail = 0;
  int lat = 0;
  bit stall = 1'b0;
  int tick = 0;
  int n_reads = 0;
  logic [31:0] rd_addr [2];
  bit pending = 1'b0;
  int cnt = 0;
  logic [31:0] pend_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_top u_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_paddr(done_paddr),
    .done_fault(done_fault)
  );

  // Memory image: directory at BASE_A valid for odd indices, at BASE_B all valid,
  // both pointing at table page 0x100+d; table entry t of page d valid when t%4 != 0,
  // with frame {t, d}. Invalid entries carry junk in the other bits.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] pg;
    logic [9:0]  ix;
    logic [9:0]  d;
    pg = a[31:12];
    ix = a[11:2];
    if (pg == BASE_A[31:12])
      return ix[0] ? {20'h00100 + 20'(ix), 11'h2A5, 1'b1} : 32'hFFFF_FFFE;
    else if (pg == BASE_B[31:12])
      return {20'h00100 + 20'(ix), 11'h000, 1'b1};
    else if (pg >= 20'h00100 && pg <= 20'h004FF) begin
      d = 10'(pg - 20'h00100);
      return (ix[1:0] != 2'b00) ? {ix, d, 11'h3C3, 1'b1} : {ix, d, 12'hFFE};
    end
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    tick <= tick + 1;
    if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
    if (pending) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_word(pend_addr);
        pending       <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (mem_req_valid && !pending && (!stall || tick[0])) begin
      mem_req_ready <= 1'b1;
      if (n_reads < 2) rd_addr[n_reads] <= mem_req_addr;
      n_reads   <= n_reads + 1;
      pending   <= 1'b1;
      cnt       <= lat;
      pend_addr <= mem_req_addr;
    end else mem_req_ready <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic base_write(input logic [31:0] v);
    @(negedge clk);
    base_wr_en = 1'b1;
    base_wr_data = v;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] efault,
                      input logic [31:0] base, input bit mid_wr);
    logic [9:0]  d;
    logic [9:0]  t;
    logic [31:0] epaddr;
    int cyc;
    d = va[31:22];
    t = va[21:12];
    epaddr = (efault == 2'd0) ? {t, d, va[11:0]} : 32'h0;
    @(negedge clk);
    n_reads = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8", "ready during walk", 32'(req_ready), 32'd0);
    if (mid_wr) begin
      base_wr_en = 1'b1;
      base_wr_data = BASE_B;
      @(negedge clk);
      base_wr_en = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R7", "done seen", 32'(done), 32'd1);
    chk(done_fault == efault, (efault == 2'd1) ? "R4" : (efault == 2'd2) ? "R5" : "R6",
        "fault code", 32'(done_fault), 32'(efault));
    chk(done_paddr == epaddr, (efault == 2'd0) ? "R1" : "R4", "physical address",
        done_paddr, epaddr);
    chk(n_reads == ((efault == 2'd1) ? 1 : 2), "R4", "read count", 32'(n_reads),
        (efault == 2'd1) ? 32'd1 : 32'd2);
    chk(rd_addr[0] == base + {20'd0, d, 2'b00}, "R2", "directory read address",
        rd_addr[0], base + {20'd0, d, 2'b00});
    if (efault != 2'd1)
      chk(rd_addr[1] == ({20'h00100 + 20'(d), 12'h000} + {20'd0, t, 2'b00}), "R3",
          "table read address", rd_addr[1],
          {20'h00100 + 20'(d), 12'h000} + {20'd0, t, 2'b00});
    @(negedge clk);
    chk(done == 1'b0, "R7", "done single cycle", 32'(done), 32'd0);
    chk(req_ready == 1'b1, "R8", "ready after done", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'd1);
    chk(mem_req_valid == 1'b0, "R11", "no memory request", 32'(mem_req_valid), 32'd0);
    chk(done == 1'b0, "R11", "done low", 32'(done), 32'd0);

    base_write(BASE_A);
    for (int i = 0; i < NVEC; i++) begin
      lat = i % 3;
      stall = (i % 2) == 1;
      walk(VEC[i][31:0], VEC[i][33:32], BASE_A, 1'b0);
    end

    // R9 heavy stalls and long latency
    lat = 4;
    stall = 1'b1;
    walk(32'h0080_3321, 2'd1, BASE_A, 1'b0);
    walk(32'h0040_3777, 2'd0, BASE_A, 1'b0);

    // R10 write during walk ignored: base stays BASE_A, even index still faults
    lat = 1;
    stall = 1'b0;
    walk(32'h0080_1004, 2'd1, BASE_A, 1'b1);
    walk(32'h0080_1004, 2'd1, BASE_A, 1'b0);

    // R10 write while idle taken: same address now maps through BASE_B
    base_write(BASE_B);
    walk(32'h0080_1004, 2'd0, BASE_B, 1'b0);
    walk(32'h0000_0ABC, 2'd2, BASE_B, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule